// File: doc/BRIEF.md
# Doorbell Mailbox Register Block

This block sits between a host processor's 32-bit register bus and an embedded core. The host posts a command by filling in a small per-core register bank: buffer address, buffer length, a sequence counter it bumps by one, and finally a command/status word with a function code and a "wait for response" flag. Writing that flag hands the command to the core side as a one-cycle request carrying the bank, function code, address and length. The core answers later with a done pulse and a 3-bit status. The block writes the answer back into the same command/status word, and the host polls that word.

A second channel runs the other way. The core pulses a notify input, which latches a pending flag in a notification status register and raises an interrupt line. The host clears the flag by writing one to it. It acknowledges through a separate reverse control word, which the block presents to the core unchanged.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset every bank register, the notification status, the reverse control word, `irq` and `cmdValid` read as zero.
- R2: Bank b occupies byte offsets b*16 to b*16+12, with one 32-bit word each for buffer address (word 0), buffer length (word 1), sequence counter (word 2) and command/status (word 3). Words 0 to 2 read back exactly what the host last wrote.
- R3: The command/status word layout is: function code in bits 14:11, static-buffer flag in bit 5, status in bits 4:2, done in bit 1, wait-for-response in bit 0. Bits the block does not update read back as written.
- R4: A host write to word 3 with bit 0 set stores the word with done forced to 0. In the following cycle, and only then, `cmdValid` is high, and `cmdBank`, `cmdFunc`, `cmdAddr` and `cmdSize` carry that bank's values.
- R5: A `cmdDone` pulse naming a bank with an outstanding command sets done (bit 1) and loads `cmdStatus` into bits 4:2 at the next clock edge. All other bits are kept. Status 1 means success and 0 means error.
- R6: A `cmdDone` pulse naming a bank with no outstanding command changes nothing.
- R7: A write to word 3 with bit 0 clear is stored as written and raises no `cmdValid`.
- R8: A `notify` pulse sets bit 8 of the notification status register at offset 0x80 and drives `irq` high. `irq` stays high until the host writes that register with bit 8 set. A write with bit 8 clear has no effect.
- R9: When `notify` and the host clear of bit 8 fall in the same cycle, the bit ends up set.
- R10: The reverse control word at offset 0x84 is read/write and always appears on `revCtrl`. A host acknowledge that clears bits 4:2 and sets bit 1 keeps the other bits.
- R11: Reads of unmapped or unaligned offsets return zero. This includes the bank region beyond the last bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe |
| regAddr | input | ADDR_W | Host byte address |
| regWdata | input | 32 | Host write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| cmdValid | output | 1 | One-cycle command request to the core |
| cmdBank | output | BANK_W | Bank of the request |
| cmdFunc | output | 4 | Function code of the request |
| cmdAddr | output | 32 | Buffer address of the request |
| cmdSize | output | 32 | Buffer length of the request |
| cmdDone | input | 1 | Core completion pulse |
| cmdDoneBank | input | BANK_W | Bank the completion refers to |
| cmdStatus | input | 3 | Completion status code |
| notify | input | 1 | Core notification pulse |
| irq | output | 1 | Pending-notification interrupt |
| revCtrl | output | 32 | Reverse control word as seen by the core |

## Verification
The core-side `notify` pulse and the host's write-one-to-clear of the notification bit can land on the same clock edge. The bench drives both in one cycle and then requires the bit to read back set, with `irq` still high. A completion on one bank can also coincide with host traffic. The modelled core answers after a random delay with success or error. Every answer is then compared against the status the host polls out of the command word.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;

  localparam int FuncLsb   = 11;
  localparam int StatusLsb = 2;
  localparam int DoneBit   = 1;
  localparam int WaitBit   = 0;
  localparam int PendBit   = 8;

  typedef enum logic [1:0] {SEL_NONE, SEL_BANK, SEL_NOTE, SEL_REV} mbox_sel_e;

  typedef struct packed {
    logic wrBuf;
    logic wrLen;
    logic wrSeq;
    logic wrCtrl;
    logic post;
    logic doneLoad;
    logic irqSet;
    logic irqClr;
    logic wrRev;
  } mbox_strobe_t;

endpackage

// File: rtl/mbox_ctrl.sv
`timescale 1ns/1ps
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 8,
  parameter int NOTE_OFS  = 'h80,
  parameter int REV_OFS   = 'h84,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int BANK_SPAN = NUM_BANKS * 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic              cmdDone,
  input  logic [BANK_W-1:0] cmdDoneBank,
  input  logic              notify,
  output mbox_strobe_t      stb,
  output mbox_sel_e         selKind,
  output logic [BANK_W-1:0] selBank,
  output logic [1:0]        selWord,
  output logic              cmdValid,
  output logic [BANK_W-1:0] cmdBank
);

  localparam logic [ADDR_W-1:0] NoteAddr = ADDR_W'(NOTE_OFS);
  localparam logic [ADDR_W-1:0] RevAddr  = ADDR_W'(REV_OFS);

  logic [NUM_BANKS-1:0] pending;
  logic bankWr;

  always_comb begin
    selKind = SEL_NONE;
    if (regAddr[1:0] == 2'b00) begin
      if (int'(regAddr) < BANK_SPAN) selKind = SEL_BANK;
      else if (regAddr == NoteAddr)  selKind = SEL_NOTE;
      else if (regAddr == RevAddr)   selKind = SEL_REV;
    end
  end

  assign selBank = regAddr[4 +: BANK_W];
  assign selWord = regAddr[3:2];
  assign bankWr  = regWrEn && (selKind == SEL_BANK);

  always_comb begin
    stb        = '0;
    stb.wrBuf  = bankWr && (selWord == 2'd0);
    stb.wrLen  = bankWr && (selWord == 2'd1);
    stb.wrSeq  = bankWr && (selWord == 2'd2);
    stb.wrCtrl = bankWr && (selWord == 2'd3);
    stb.post   = stb.wrCtrl && regWdata[WaitBit];
    stb.doneLoad = cmdDone && pending[cmdDoneBank] &&
                   !(stb.wrCtrl && (selBank == cmdDoneBank));
    stb.irqSet = notify;
    stb.irqClr = regWrEn && (selKind == SEL_NOTE) && regWdata[PendBit];
    stb.wrRev  = regWrEn && (selKind == SEL_REV);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= '0;
      cmdValid <= 1'b0;
      cmdBank  <= '0;
    end else begin
      if (stb.doneLoad) pending[cmdDoneBank] <= 1'b0;
      if (stb.post)     pending[selBank]     <= 1'b1;
      cmdValid <= stb.post;
      if (stb.post) cmdBank <= selBank;
    end
  end

  // R4: a request is only presented for a bank that holds an outstanding command
  assert_req_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> pending[cmdBank]);

endmodule

// File: rtl/mbox_datapath.sv
`timescale 1ns/1ps
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbox_strobe_t      stb,
  input  mbox_sel_e         selKind,
  input  logic [BANK_W-1:0] selBank,
  input  logic [1:0]        selWord,
  input  logic [31:0]       wdata,
  input  logic [BANK_W-1:0] doneBank,
  input  logic [2:0]        doneStatus,
  input  logic [BANK_W-1:0] cmdBank,
  output logic [31:0]       rdata,
  output logic [3:0]        cmdFunc,
  output logic [31:0]       cmdAddr,
  output logic [31:0]       cmdSize,
  output logic              irq,
  output logic [31:0]       revCtrl
);

  logic [31:0] bufAddr [NUM_BANKS];
  logic [31:0] bufLen  [NUM_BANKS];
  logic [31:0] seqCnt  [NUM_BANKS];
  logic [31:0] ctrlW   [NUM_BANKS];
  logic        pendBit;
  logic [31:0] revW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        bufAddr[b] <= '0;
        bufLen[b]  <= '0;
        seqCnt[b]  <= '0;
        ctrlW[b]   <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (stb.wrBuf && selBank == BANK_W'(b)) bufAddr[b] <= wdata;
        if (stb.wrLen && selBank == BANK_W'(b)) bufLen[b]  <= wdata;
        if (stb.wrSeq && selBank == BANK_W'(b)) seqCnt[b]  <= wdata;
        if (stb.wrCtrl && selBank == BANK_W'(b)) begin
          ctrlW[b] <= wdata;
          if (stb.post) ctrlW[b][DoneBit] <= 1'b0;
        end else if (stb.doneLoad && doneBank == BANK_W'(b)) begin
          ctrlW[b][StatusLsb +: 3] <= doneStatus;
          ctrlW[b][DoneBit]        <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendBit <= 1'b0;
      revW    <= '0;
    end else begin
      if (stb.irqSet)      pendBit <= 1'b1;
      else if (stb.irqClr) pendBit <= 1'b0;
      if (stb.wrRev) revW <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (selKind)
      SEL_BANK: begin
        case (selWord)
          2'd0:    rdata = bufAddr[selBank];
          2'd1:    rdata = bufLen[selBank];
          2'd2:    rdata = seqCnt[selBank];
          default: rdata = ctrlW[selBank];
        endcase
      end
      SEL_NOTE: rdata[PendBit] = pendBit;
      SEL_REV:  rdata = revW;
      default:  rdata = '0;
    endcase
  end

  assign cmdFunc = ctrlW[cmdBank][FuncLsb +: 4];
  assign cmdAddr = bufAddr[cmdBank];
  assign cmdSize = bufLen[cmdBank];
  assign irq     = pendBit;
  assign revCtrl = revW;

  // R8: the interrupt only rises after a core notification
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(stb.irqSet));

  // R9: a notification always leaves the interrupt pending, even against a clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.irqSet |=> irq);

  // R5: bank 0 done bit only rises on a completion or a host write
  assert_done_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlW[0][DoneBit]) |-> $past(stb.doneLoad || stb.wrCtrl));

  // R10: the reverse word holds without a host write to it
  assert_rev_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrRev |=> $stable(revCtrl));

endmodule

// File: rtl/mbox_doorbell.sv
`timescale 1ns/1ps
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              cmdValid,
  output logic [BANK_W-1:0] cmdBank,
  output logic [3:0]        cmdFunc,
  output logic [31:0]       cmdAddr,
  output logic [31:0]       cmdSize,
  input  logic              cmdDone,
  input  logic [BANK_W-1:0] cmdDoneBank,
  input  logic [2:0]        cmdStatus,
  input  logic              notify,
  output logic              irq,
  output logic [31:0]       revCtrl
);

  mbox_strobe_t      stb;
  mbox_sel_e         selKind;
  logic [BANK_W-1:0] selBank;
  logic [1:0]        selWord;

  mbox_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .cmdDone(cmdDone), .cmdDoneBank(cmdDoneBank),
    .notify(notify), .stb(stb), .selKind(selKind), .selBank(selBank),
    .selWord(selWord), .cmdValid(cmdValid), .cmdBank(cmdBank)
  );

  mbox_datapath #(.NUM_BANKS(NUM_BANKS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .selKind(selKind), .selBank(selBank),
    .selWord(selWord), .wdata(regWdata), .doneBank(cmdDoneBank),
    .doneStatus(cmdStatus), .cmdBank(cmdBank), .rdata(regRdata),
    .cmdFunc(cmdFunc), .cmdAddr(cmdAddr), .cmdSize(cmdSize), .irq(irq),
    .revCtrl(revCtrl)
  );

endmodule

// File: tb/mbox_doorbell_tb_top.sv
`timescale 1ns/1ps
module mbox_doorbell_tb_top;

  localparam int NB = 4;
  localparam int BW = 2;

  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic cmdValid;
  logic [BW-1:0] cmdBank;
  logic [3:0] cmdFunc;
  logic [31:0] cmdAddr, cmdSize;
  logic cmdDone = 0;
  logic [BW-1:0] cmdDoneBank = '0;
  logic [2:0] cmdStatus = '0;
  logic notify = 0;
  logic irq;
  logic [31:0] revCtrl;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  typedef struct {
    int bank;
    logic [3:0] func;
    logic [31:0] addr;
    logic [31:0] size;
  } exp_cmd_t;

  exp_cmd_t expQ[$];
  logic [2:0] statQ[$];
  int injReq = 0;
  int injAck = 0;
  int injBank = 0;
  logic [2:0] injStat = '0;

  always #4 clk = ~clk;

  mbox_doorbell #(.NUM_BANKS(NB), .ADDR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cmdValid(cmdValid),
    .cmdBank(cmdBank), .cmdFunc(cmdFunc), .cmdAddr(cmdAddr),
    .cmdSize(cmdSize), .cmdDone(cmdDone), .cmdDoneBank(cmdDoneBank),
    .cmdStatus(cmdStatus), .notify(notify), .irq(irq), .revCtrl(revCtrl)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk);
    d = regRdata;
  endtask

  // driver: posts one command and pushes the expected request
  task automatic post(int bank, logic [3:0] func, logic [31:0] adr,
                      logic [31:0] len, bit stat);
    logic [31:0] seq, v;
    logic [7:0] base;
    exp_cmd_t e;
    base = 8'(bank * 16);
    wr(base, adr);
    wr(base + 8'd4, len);
    rd(base + 8'd8, seq);
    wr(base + 8'd8, seq + 1);
    rd(base + 8'd8, v);
    check("R2 seq increment", v, seq + 1);
    e.bank = bank; e.func = func; e.addr = adr; e.size = len;
    expQ.push_back(e);
    wr(base + 8'd12, {17'd0, func, 5'd0, stat, 5'd1});
    rd(base + 8'd12, v);
    check("R4 done cleared on post", {31'd0, v[1]}, 32'd0);
  endtask

  // monitor: scoreboard for core-side requests
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && cmdValid) begin
        nChecks++;
        if (expQ.size() == 0) begin
          nFails++;
          $display("FAIL R4/R7 unexpected cmdValid actual=1 expected=0");
        end else begin
          exp_cmd_t e;
          e = expQ.pop_front();
          check("R4 cmdBank", 32'(cmdBank), 32'(e.bank));
          check("R4 cmdFunc", 32'(cmdFunc), 32'(e.func));
          check("R4 cmdAddr", cmdAddr, e.addr);
          check("R4 cmdSize", cmdSize, e.size);
        end
      end
    end
  end

  // core model: answers requests after a random delay, or injects on demand
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && cmdValid) begin
        int b;
        logic [2:0] st;
        b = int'(cmdBank);
        st = ($urandom % 2 == 0) ? 3'd1 : 3'd0;
        statQ.push_back(st);
        repeat ($urandom_range(2, 12)) @(posedge clk);
        #1;
        cmdDone = 1; cmdDoneBank = BW'(b); cmdStatus = st;
        @(posedge clk); #1;
        cmdDone = 0;
      end else if (injReq != injAck) begin
        @(posedge clk); #1;
        cmdDone = 1; cmdDoneBank = BW'(injBank); cmdStatus = injStat;
        @(posedge clk); #1;
        cmdDone = 0;
        injAck++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v, w;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    rd(8'h00, v); check("R1 buf addr", v, 0);
    rd(8'h0C, v); check("R1 ctrl word", v, 0);
    rd(8'h80, v); check("R1 note status", v, 0);
    rd(8'h84, v); check("R1 reverse word", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 cmdValid", {31'd0, cmdValid}, 0);

    // R2 bank layout read-back
    wr(8'h20, 32'hA5A5_0001);
    wr(8'h24, 32'h0000_0040);
    wr(8'h28, 32'h0000_0007);
    rd(8'h20, v); check("R2 bank2 word0", v, 32'hA5A5_0001);
    rd(8'h24, v); check("R2 bank2 word1", v, 32'h0000_0040);
    rd(8'h28, v); check("R2 bank2 word2", v, 32'h0000_0007);
    rd(8'h10, v); check("R2 bank1 untouched", v, 0);

    // R3 R4 R5: posts across all banks, random success/error answers
    for (int i = 0; i < 10; i++) begin
      int bk;
      logic [3:0] fn;
      bit sf;
      int tries;
      bk = i % NB;
      fn = 4'(i + 3);
      sf = i[0];
      post(bk, fn, 32'h1000_0000 + 32'(i * 256), 32'(24 + i), sf);
      tries = 0;
      do begin
        rd(8'(bk * 16 + 12), v);
        tries++;
      end while (!v[1] && tries < 40);
      check("R5 done set", {31'd0, v[1]}, 1);
      if (statQ.size() > 0) begin
        logic [2:0] es;
        es = statQ.pop_front();
        check("R5 status loaded", 32'(v[4:2]), 32'(es));
      end else check("R5 status queue", 0, 1);
      check("R3 func kept", 32'(v[14:11]), 32'(fn));
      check("R3 static flag kept", {31'd0, v[5]}, {31'd0, sf});
      check("R3 wait flag kept", {31'd0, v[0]}, 1);
    end

    // R6 completion to idle bank is ignored
    rd(8'h1C, w);
    injBank = 1; injStat = 3'd5; injReq++;
    wait (injAck == injReq);
    repeat (2) @(posedge clk);
    rd(8'h1C, v); check("R6 ignored done", v, w);

    // R7 control write without wait flag
    wr(8'h2C, 32'h0000_4026);
    repeat (4) @(posedge clk);
    rd(8'h2C, v); check("R7 stored as written", v, 32'h0000_4026);
    check("R7 no request queued", 32'(expQ.size()), 0);

    // R8 notification and clear
    @(posedge clk); #1 notify = 1;
    @(posedge clk); #1 notify = 0;
    @(negedge clk); check("R8 irq raised", {31'd0, irq}, 1);
    rd(8'h80, v); check("R8 pending bit", v, 32'h100);
    wr(8'h80, 32'h0000_00FF);
    @(negedge clk); check("R8 clear ignores bit8=0", {31'd0, irq}, 1);
    wr(8'h80, 32'h0000_0100);
    @(negedge clk); check("R8 cleared", {31'd0, irq}, 0);

    // R9 notify and clear same cycle
    @(posedge clk); #1;
    notify = 1; regWrEn = 1; regAddr = 8'h80; regWdata = 32'h100;
    @(posedge clk); #1;
    notify = 0; regWrEn = 0;
    @(negedge clk); check("R9 set wins irq", {31'd0, irq}, 1);
    rd(8'h80, v); check("R9 set wins bit", v, 32'h100);
    wr(8'h80, 32'h100);

    // R10 reverse control word and acknowledge
    wr(8'h84, 32'h0000_581F);
    rd(8'h84, v); check("R10 readback", v, 32'h0000_581F);
    @(negedge clk); check("R10 port", revCtrl, 32'h0000_581F);
    wr(8'h84, (v & ~32'h1C) | 32'h2);
    rd(8'h84, v); check("R10 acknowledge", v, 32'h0000_5803);

    // R11 unmapped reads
    rd(8'h40, v); check("R11 beyond banks", v, 0);
    rd(8'h88, v); check("R11 past reverse", v, 0);
    rd(8'h02, v); check("R11 unaligned", v, 0);

    repeat (5) @(posedge clk);
    check("R4 scoreboard drained", 32'(expQ.size()), 0);
    finishRun();
  end

endmodule